// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

This block collects interrupt flags from up to fifteen peripheral slots and turns them into one prioritised request for a processor core. Each slot keeps a sticky flag register and a per-flag enable register. Hardware event pulses set the flags. Software clears a flag by writing a one to it. The slot's enables are changed through a separate set strobe and a separate clear strobe. The enabled flags of one slot are ORed into a single line, and slot `s` drives vector line `s`.

At controller level, each line latches into a pending bit. The pending bit is masked by a controller enable, and the surviving lines compete by a programmable 2-bit priority. The winning vector number comes out with a valid strobe. When the core acknowledges it, that vector's pending bit is cleared. A non-maskable request input is passed straight to its output and is untouched by any enable or priority. Software reaches every register through an 8-bit address, 32-bit data write port qualified by a valid strobe. The read data is available combinationally in the same cycle the address is presented.

Top module: `intc_top`

## Requirements
- R1: A flag bit is set by a one on its event input and stays set until a one is written to that bit at slot register `4*s+0`. An event and a clearing write to the same bit in the same cycle leave the bit set. Reading `4*s+0` returns the flags in bits [7:0].
- R2: Writing a one to a bit at `4*s+1` enables that flag, and zero bits leave enables unchanged. Reading `4*s+1` or `4*s+2` returns the enables.
- R3: Writing a one to a bit at `4*s+2` disables that flag, and zero bits leave enables unchanged.
- R4: Slot `s` drives line `s` high while any of its flags is both set and enabled. A high line sets pending bit `s` at the next clock edge.
- R5: Writing ones to 0x40 sets pending bits, and writing ones to 0x41 clears them. A software clear wins over a hardware set in the same cycle. Reading 0x40 or 0x41 returns all pending bits.
- R6: Writing ones to 0x42 sets controller enables, and writing ones to 0x43 clears them. Reading either address returns the enables. A line is presented only when it is both pending and enabled.
- R7: Priority register `r` (address 0x48+r, r=0..7) holds the 2-bit field of vector `4r+j` at bits [8j+1:8j]. The lowest value wins, and among equal values the lowest vector wins. The vector appears on `irq_vec_o` in the same cycle as the state that makes it win.
- R8: Vectors from 15 through 31 are reserved. Their pending and enable bits always read zero, and they are never presented.
- R9: `nmi_o` follows `nmi_i` at all times, regardless of any enable or priority.
- R10: `ack_i` while `irq_valid_o` is high clears the pending bit of the presented vector at that edge. If the source line is still high, the bit sets again at the following edge.
- R11: After reset, all flags, enables, pending bits and priorities are zero, and `irq_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | N_SLOT*FLAG_W | Event pulses; bit `s*FLAG_W+b` sets flag `b` of slot `s` |
| reg_wr_i | input | 1 | Register write valid |
| reg_addr_i | input | 8 | Register address for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, same cycle |
| ack_i | input | 1 | Core accepts the presented vector |
| nmi_i | input | 1 | Non-maskable request in |
| nmi_o | output | 1 | Non-maskable request out |
| irq_valid_o | output | 1 | A vector is being presented |
| irq_vec_o | output | 5 | Presented vector number |

## Verification
The bound checker watches several properties on every cycle. It confirms that a presented vector is pending, enabled and not reserved, and that no request appears when no line is both pending and enabled. It confirms that an acknowledged vector's pending bit is low on the next cycle, and that reserved pending bits stay zero. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle model:
- the priority order among competing lines;
- the win of an event over a same-cycle clearing write;
- the inert effect of zero bits in the set and clear writes;
- the one-cycle delay from flag to pending;
- the re-arming of a pending bit after an acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NVEC   = 32;
    localparam int PRIO_W = 2;
    localparam int VEC_W  = $clog2(NVEC);
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PR_PER_REG = 4;

    localparam logic [ADDR_W-1:0] A_PEND_SET = 8'h40;
    localparam logic [ADDR_W-1:0] A_PEND_CLR = 8'h41;
    localparam logic [ADDR_W-1:0] A_CEN_SET  = 8'h42;
    localparam logic [ADDR_W-1:0] A_CEN_CLR  = 8'h43;
    localparam logic [4:0]        A_PRIO_HI  = 5'b01001;

    typedef enum logic [1:0] {
        K_FLAG  = 2'd0,
        K_ENSET = 2'd1,
        K_ENCLR = 2'd2,
        K_NONE  = 2'd3
    } slot_reg_e;

    typedef struct packed {
        logic [NVEC-1:0]              pend;
        logic [NVEC-1:0]              cen;
        logic [NVEC-1:0][PRIO_W-1:0]  prio;
    } ctl_t;

    function automatic logic [NVEC-1:0] low_ones(input int n);
        logic [NVEC-1:0] m;
        m = '0;
        for (int i = 0; i < NVEC; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/intc_slot.sv
module intc_slot #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] ev_i,
    input  logic [FLAG_W-1:0] w1c_i,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flag_o,
    output logic [FLAG_W-1:0] en_o,
    output logic              line_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] flag;
        logic [FLAG_W-1:0] en;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // event has priority over a same-cycle software clear
        st_d.flag = (st_q.flag & ~w1c_i) | ev_i;
        st_d.en   = (st_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
    assign line_o = |(st_q.flag & st_q.en);
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int NREQ = 32,
    parameter int PW   = 2,
    parameter int IW   = $clog2(NREQ)
) (
    input  logic [NREQ-1:0]         req_i,
    input  logic [NREQ-1:0][PW-1:0] prio_i,
    output logic                    valid_o,
    output logic [IW-1:0]           idx_o
);
    logic          found;
    logic [PW-1:0] best;
    logic [IW-1:0] idx;

    always_comb begin
        found = 1'b0;
        best  = '1;
        idx   = '0;
        // ascending scan with strict compare: ties keep the lower index
        for (int i = 0; i < NREQ; i++) begin
            if (req_i[i] && (!found || prio_i[i] < best)) begin
                found = 1'b1;
                best  = prio_i[i];
                idx   = IW'(i);
            end
        end
        valid_o = found;
        idx_o   = idx;
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int N_SLOT = 15,
    parameter int FLAG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SLOT*FLAG_W-1:0] ev_i,
    input  logic                     reg_wr_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    input  logic                     ack_i,
    input  logic                     nmi_i,
    output logic                     nmi_o,
    output logic                     irq_valid_o,
    output logic [VEC_W-1:0]         irq_vec_o
);
    localparam logic [NVEC-1:0] LIVE = low_ones(N_SLOT);

    ctl_t st_d, st_q;

    logic [N_SLOT-1:0][FLAG_W-1:0] flag_w, en_w;
    logic [NVEC-1:0]               line_w;
    logic [NVEC-1:0]               pend_vec, cen_vec;
    logic                          slot_wr;
    logic [3:0]                    slot_idx;
    logic [1:0]                    slot_kind;

    assign slot_wr   = reg_wr_i && (reg_addr_i[7:6] == 2'b00);
    assign slot_idx  = reg_addr_i[5:2];
    assign slot_kind = reg_addr_i[1:0];

    genvar s;
    generate
        for (s = 0; s < N_SLOT; s++) begin : g_slot
            logic              hit;
            logic [FLAG_W-1:0] w1c, eset, eclr;
            logic              line_s;
            assign hit  = slot_wr && (slot_idx == 4'(s));
            assign w1c  = (hit && slot_kind == K_FLAG)  ? reg_wdata_i[FLAG_W-1:0] : '0;
            assign eset = (hit && slot_kind == K_ENSET) ? reg_wdata_i[FLAG_W-1:0] : '0;
            assign eclr = (hit && slot_kind == K_ENCLR) ? reg_wdata_i[FLAG_W-1:0] : '0;
            intc_slot #(.FLAG_W(FLAG_W)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .ev_i   (ev_i[s*FLAG_W +: FLAG_W]),
                .w1c_i  (w1c),
                .set_i  (eset),
                .clr_i  (eclr),
                .flag_o (flag_w[s]),
                .en_o   (en_w[s]),
                .line_o (line_s)
            );
            assign line_w[s] = line_s;
        end
        for (s = N_SLOT; s < NVEC; s++) begin : g_rsvd
            assign line_w[s] = 1'b0;
        end
    endgenerate

    intc_arb #(.NREQ(NVEC), .PW(PRIO_W), .IW(VEC_W)) u_arb (
        .req_i   (st_q.pend & st_q.cen),
        .prio_i  (st_q.prio),
        .valid_o (irq_valid_o),
        .idx_o   (irq_vec_o)
    );

    always_comb begin
        logic [NVEC-1:0] pset, pclr, cset, cclr, ack_mask;
        st_d     = st_q;
        pset     = (reg_wr_i && reg_addr_i == A_PEND_SET) ? reg_wdata_i[NVEC-1:0] : '0;
        pclr     = (reg_wr_i && reg_addr_i == A_PEND_CLR) ? reg_wdata_i[NVEC-1:0] : '0;
        cset     = (reg_wr_i && reg_addr_i == A_CEN_SET)  ? reg_wdata_i[NVEC-1:0] : '0;
        cclr     = (reg_wr_i && reg_addr_i == A_CEN_CLR)  ? reg_wdata_i[NVEC-1:0] : '0;
        ack_mask = (ack_i && irq_valid_o) ? (NVEC'(1) << irq_vec_o) : '0;
        st_d.pend = (st_q.pend | line_w | pset) & ~pclr & ~ack_mask & LIVE;
        st_d.cen  = (st_q.cen | cset) & ~cclr & LIVE;
        if (reg_wr_i && reg_addr_i[7:3] == A_PRIO_HI) begin
            for (int j = 0; j < PR_PER_REG; j++) begin
                st_d.prio[{reg_addr_i[2:0], 2'(j)}] = reg_wdata_i[8*j +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i[7:6] == 2'b00) begin
            for (int i = 0; i < N_SLOT; i++) begin
                if (slot_idx == 4'(i)) begin
                    if (slot_kind == K_FLAG)
                        reg_rdata_o[FLAG_W-1:0] = flag_w[i];
                    else if (slot_kind == K_ENSET || slot_kind == K_ENCLR)
                        reg_rdata_o[FLAG_W-1:0] = en_w[i];
                end
            end
        end else if (reg_addr_i == A_PEND_SET || reg_addr_i == A_PEND_CLR) begin
            reg_rdata_o[NVEC-1:0] = st_q.pend;
        end else if (reg_addr_i == A_CEN_SET || reg_addr_i == A_CEN_CLR) begin
            reg_rdata_o[NVEC-1:0] = st_q.cen;
        end else if (reg_addr_i[7:3] == A_PRIO_HI) begin
            for (int j = 0; j < PR_PER_REG; j++) begin
                reg_rdata_o[8*j +: PRIO_W] = st_q.prio[{reg_addr_i[2:0], 2'(j)}];
            end
        end
    end

    assign pend_vec = st_q.pend;
    assign cen_vec  = st_q.cen;
    assign nmi_o    = nmi_i;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int NVEC   = 32,
    parameter int N_SLOT = 15,
    parameter int VEC_W  = $clog2(NVEC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             irq_valid_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic [NVEC-1:0]  pend,
    input logic [NVEC-1:0]  cen
);
    p_sel_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (pend[irq_vec_o] && cen[irq_vec_o]));

    p_sel_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (32'(irq_vec_o) < N_SLOT));

    p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend >> N_SLOT) == '0);

    p_idle_when_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & cen) == '0) |-> !irq_valid_o);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && ack_i) |=> !pend[$past(irq_vec_o)]);
endmodule

bind intc_top intc_chk #(.NVEC(intc_pkg::NVEC), .N_SLOT(N_SLOT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_valid_o (irq_valid_o),
    .irq_vec_o   (irq_vec_o),
    .pend        (pend_vec),
    .cen         (cen_vec)
);

// File: tb/test_intc_top.sv
module test_intc_top;
    localparam int N  = 15;
    localparam int FW = 8;
    localparam int NV = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N*FW-1:0]   ev = '0;
    logic              wr = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              ack = 1'b0;
    logic              nmi = 1'b0;
    logic              nmi_o;
    logic              valid;
    logic [4:0]        vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [FW-1:0] m_flag [N];
    logic [FW-1:0] m_en   [N];
    logic [NV-1:0] m_pend, m_cen;
    logic [1:0]    m_prio [NV];

    always #10 clk = ~clk;

    intc_top #(.N_SLOT(N), .FLAG_W(FW)) i_intc_top (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .nmi_i(nmi),
        .nmi_o(nmi_o), .irq_valid_o(valid), .irq_vec_o(vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference winner: descending scan, lower-or-equal value replaces
    function automatic int m_win();
        int best = -1;
        for (int i = NV - 1; i >= 0; i--) begin
            if (m_pend[i] && m_cen[i] && (best < 0 || m_prio[i] <= m_prio[best])) best = i;
        end
        return best;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a[7:6] == 2'b00) begin
            if (int'(a[5:2]) < N) begin
                if (a[1:0] == 2'd0) r[FW-1:0] = m_flag[a[5:2]];
                else if (a[1:0] != 2'd3) r[FW-1:0] = m_en[a[5:2]];
            end
        end else if (a == 8'h40 || a == 8'h41) r = m_pend;
        else if (a == 8'h42 || a == 8'h43) r = m_cen;
        else if (a[7:3] == 5'b01001) begin
            for (int j = 0; j < 4; j++) r[8*j +: 2] = m_prio[int'(a[2:0])*4 + j];
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a[7:6] == 2'b00) return (a[1:0] == 2'd0) ? "R1" : "R2";
        if (a == 8'h40 || a == 8'h41) return "R5";
        if (a == 8'h42 || a == 8'h43) return "R6";
        return "R7";
    endfunction

    function automatic void m_step(input logic [N*FW-1:0] e, input logic w, input logic [7:0] a,
                                   input logic [31:0] d, input logic k);
        logic [NV-1:0] lines = '0, am = '0, live = '0;
        int win;
        for (int s = 0; s < N; s++) begin
            lines[s] = |(m_flag[s] & m_en[s]);
            live[s]  = 1'b1;
        end
        win = m_win();
        if (k && win >= 0) am[win] = 1'b1;
        for (int s = 0; s < N; s++) begin
            logic [FW-1:0] c = (w && a == 8'(4*s))     ? d[FW-1:0] : '0;
            logic [FW-1:0] p = (w && a == 8'(4*s + 1)) ? d[FW-1:0] : '0;
            logic [FW-1:0] q = (w && a == 8'(4*s + 2)) ? d[FW-1:0] : '0;
            m_flag[s] = (m_flag[s] & ~c) | e[s*FW +: FW];
            m_en[s]   = (m_en[s] | p) & ~q;
        end
        m_pend = (m_pend | lines | ((w && a == 8'h40) ? d : 32'h0))
                 & ~((w && a == 8'h41) ? d : 32'h0) & ~am & live;
        m_cen  = (m_cen | ((w && a == 8'h42) ? d : 32'h0))
                 & ~((w && a == 8'h43) ? d : 32'h0) & live;
        if (w && a[7:3] == 5'b01001)
            for (int j = 0; j < 4; j++) m_prio[int'(a[2:0])*4 + j] = d[8*j +: 2];
    endfunction

    task automatic model_cmp();
        int w = m_win();
        chk("R7", {31'd0, valid}, {31'd0, w >= 0});
        if (w >= 0) chk("R7", {27'd0, vec}, 32'(w));
        chk(tag_of(addr), rdata, m_read(addr));
    endtask

    task automatic cyc(input logic [N*FW-1:0] e, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic k);
        ev = e; wr = w; addr = a; wdata = d; ack = k;
        m_step(e, w, a, d, k);
        @(negedge clk);
        ev = '0; wr = 1'b0; ack = 1'b0;
        model_cmp();
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [N*FW-1:0] evbit(input int s, input int b);
        logic [N*FW-1:0] e = '0;
        e[s*FW + b] = 1'b1;
        return e;
    endfunction

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  ra;
        void'($urandom(32'd4242));
        for (int s = 0; s < N; s++) begin m_flag[s] = '0; m_en[s] = '0; end
        for (int i = 0; i < NV; i++) m_prio[i] = '0;
        m_pend = '0; m_cen = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11", {31'd0, valid}, 32'd0);
        rd(8'h40, v); chk("R11", v, 32'h0);
        rd(8'h48, v); chk("R11", v, 32'h0);
        rd(8'h0D, v); chk("R11", v, 32'h0);

        // R1 sticky flag, event beats clear
        cyc(evbit(3, 2), 1'b0, 8'h00, 32'h0, 1'b0);
        rd(8'h0C, v); chk("R1", v, 32'h04);
        cyc(evbit(3, 2), 1'b1, 8'h0C, 32'h04, 1'b0);
        rd(8'h0C, v); chk("R1", v, 32'h04);
        cyc('0, 1'b1, 8'h0C, 32'h04, 1'b0);
        rd(8'h0C, v); chk("R1", v, 32'h00);
        cyc(evbit(3, 2), 1'b0, 8'h00, 32'h0, 1'b0);

        // R2 enable set; zero bits inert
        cyc('0, 1'b1, 8'h0D, 32'h05, 1'b0);
        cyc('0, 1'b1, 8'h0D, 32'h00, 1'b0);
        rd(8'h0E, v); chk("R2", v, 32'h05);
        // R4 line -> pending bit 3; R6 not presented while disabled
        rd(8'h40, v); chk("R4", v, 32'h08);
        chk("R6", {31'd0, valid}, 32'd0);

        // R3 enable clear
        cyc('0, 1'b1, 8'h0E, 32'h01, 1'b0);
        rd(8'h0D, v); chk("R3", v, 32'h04);

        // R6 controller enable
        cyc('0, 1'b1, 8'h42, 32'h08, 1'b0);
        chk("R6", {31'd0, valid}, 32'd1);
        chk("R6", {27'd0, vec}, 32'd3);

        // R10 acknowledge clears, then re-arms from live line
        cyc('0, 1'b0, 8'h00, 32'h0, 1'b1);
        rd(8'h40, v); chk("R10", v & 32'h08, 32'h0);
        chk("R10", {31'd0, valid}, 32'd0);
        cyc('0, 1'b0, 8'h00, 32'h0, 1'b0);
        chk("R10", {31'd0, valid}, 32'd1);

        // R7 tie and priority
        cyc('0, 1'b1, 8'h40, 32'h20, 1'b0);
        cyc('0, 1'b1, 8'h42, 32'h20, 1'b0);
        chk("R7", {27'd0, vec}, 32'd3);
        cyc('0, 1'b1, 8'h48, 32'h0200_0000, 1'b0);
        chk("R7", {27'd0, vec}, 32'd5);
        rd(8'h48, v); chk("R7", v, 32'h0200_0000);

        // R5 software pending clear
        cyc('0, 1'b1, 8'h41, 32'h20, 1'b0);
        chk("R5", {27'd0, vec}, 32'd3);
        rd(8'h40, v); chk("R5", v, 32'h08);

        // R6 controller disable
        cyc('0, 1'b1, 8'h43, 32'h08, 1'b0);
        chk("R6", {31'd0, valid}, 32'd0);

        // R8 reserved vectors
        cyc('0, 1'b1, 8'h40, 32'hFFFF_8000, 1'b0);
        cyc('0, 1'b1, 8'h42, 32'hFFFF_8000, 1'b0);
        rd(8'h40, v); chk("R8", v, 32'h08);
        rd(8'h42, v); chk("R8", v, 32'h20);
        chk("R8", {31'd0, valid}, 32'd0);

        // R9 non-maskable pass-through
        nmi = 1'b1; #1; chk("R9", {31'd0, nmi_o}, 32'd1);
        nmi = 1'b0; #1; chk("R9", {31'd0, nmi_o}, 32'd0);

        // constrained random against the model
        for (int t = 0; t < 4000; t++) begin
            logic [N*FW-1:0] e = '0;
            logic w = ($urandom % 3) == 0;
            logic [31:0] d = $urandom;
            for (int s = 0; s < N; s++)
                if ($urandom % 12 == 0) e[s*FW + ($urandom % FW)] = 1'b1;
            case ($urandom % 4)
                0: ra = 8'($urandom % 64);
                1: ra = 8'h40 + 8'($urandom % 4);
                2: ra = 8'h48 + 8'($urandom % 8);
                default: ra = 8'(4 * ($urandom % N) + ($urandom % 3));
            endcase
            if (w && (ra == 8'h40 || ra == 8'h42)) d = d & 32'h0000_7FFF & $urandom;
            if (w && ra[7:6] == 2'b00 && ra[1:0] != 2'd1) d = d | $urandom;
            cyc(e, w, ra, d, ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule